// File: doc/BRIEF.md
# Fan Tachometer Measurement Engine

This block times the speed of several fans. Each fan's tach signal enters through a two-flop synchroniser and an edge detector. Software asks for one reading at a time by raising a bit in the trigger word. The engine then waits for the first qualifying edge on that channel. From that edge it counts prescaled clock ticks until the next qualifying edge, and posts the count together with a done flag.

Each channel names one of eight PWM ports through a 3-bit source select. That port selects a timing profile. The profile supplies three settings: which edges count, the tach clock divide, and the longest time a reading may take. If the reading does not finish within that time, the engine posts a saturated count so that software never waits for ever. Converting the count to a fan speed is left to software.

Top module: `tach_engine`

## Requirements
- R1: After reset `result_o` reads zero.
- R2: A 0-to-1 change of `trig_i[n]` on an enabled channel n starts a reading on that channel and clears the done flag. A trigger bit held high starts nothing further. To re-measure, software clears the bit and sets it again.
- R3: `result_o` carries the done flag in bit 31 and the count in bits 19:0. Bits 30:20 read zero.
- R4: The count equals floor(P / D). P is the number of clock cycles between two consecutive qualifying edges. D is the tach divide, 4 << (2 × div), where div is the profile's 2-bit divide field (div = 0, 1, 2 gives D = 4, 16, 64).
- R5: The 2-bit edge mode selects the qualifying edges: 2'b00 counts falling edges, 2'b01 rising edges and 2'b10 both edges. With both edges and a 50 % duty signal the count is half the single-edge count. The code 2'b11 is reserved and no edge qualifies under it.
- R6: The window is counted in prescaled ticks from the start of the reading. If the reading has not completed when the window expires, the done flag is set and the count reads 20'hFFFFF.
- R7: Channel n's PWM port is {`src_hi_i[n]`, `src_lo_i[2n+1:2n]`}. Port p's profile index is `port_prof_i[2p+1:2p]`. An index of 3 or more selects profile 0.
- R8: A trigger edge on a channel whose `chan_en_i` bit is low is ignored, and `result_o` keeps its value.
- R9: When several trigger bits rise in the same cycle, the enabled channel with the lowest index is measured.
- R10: A new trigger edge during a reading abandons that reading and starts the newly triggered channel.
- R11: The profile settings are captured when the reading starts. Changing them during the reading does not alter its result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tach_i | input | NUM_CH | Asynchronous tach inputs |
| chan_en_i | input | NUM_CH | Per-channel enable |
| src_lo_i | input | 2*NUM_CH | Low two bits of each channel's PWM port select, two bits per channel |
| src_hi_i | input | NUM_CH | High bit of each channel's PWM port select |
| port_prof_i | input | 2*8 | Profile index of each PWM port |
| prof_mode_i | input | 2*NUM_PROF | Edge mode of each profile |
| prof_div_i | input | DIV_W*NUM_PROF | Tach divide field of each profile |
| prof_win_i | input | WIN_W*NUM_PROF | Measurement window of each profile, in prescaled ticks |
| trig_i | input | NUM_CH | Trigger word; a rising bit starts a reading |
| result_o | output | 32 | Done flag in bit 31, count in bits 19:0 |

## Verification
The assertions assume two things. The profile and routing inputs are steady in the cycle a trigger edge is taken. A channel's enable does not change in the same cycle as its own trigger edge. The stimulus respects both: it changes configuration only on the falling clock edge, at least two cycles away from any trigger edge. The one exception is the capture test, which changes the divide deliberately after the reading has already started.

The tach waveforms come from counters in the bench. Their high and low times are whole numbers of cycles, so every expected count follows from floor division. Both-edge readings use only equal high and low times, so the expected count does not depend on which edge comes first.

// File: rtl/tach_pkg.sv
package tach_pkg;
    localparam int CNT_W = 20;
    localparam int RES_W = 32;
    localparam int SRC_W = 3;
    localparam int NUM_PWM = 2 ** SRC_W;

    typedef enum logic [1:0] {
        EDGE_FALL = 2'b00,
        EDGE_RISE = 2'b01,
        EDGE_BOTH = 2'b10,
        EDGE_RSVD = 2'b11
    } edge_mode_e;

    typedef enum logic [1:0] {
        M_IDLE = 2'd0,
        M_ARM  = 2'd1,
        M_RUN  = 2'd2
    } meas_state_e;
endpackage

// File: rtl/tach_sync.sv
module tach_sync #(
    parameter int NUM_CH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] tach_i,
    output logic [NUM_CH-1:0] rise_o,
    output logic [NUM_CH-1:0] fall_o
);
    typedef struct packed {
        logic [NUM_CH-1:0] s1;
        logic [NUM_CH-1:0] s2;
        logic [NUM_CH-1:0] prev;
    } sync_t;

    sync_t d, q;

    always_comb begin
        d      = q;
        d.s1   = tach_i;
        d.s2   = q.s1;
        d.prev = q.s2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    for (genvar n = 0; n < NUM_CH; n++) begin : g_edge
        assign rise_o[n] =  q.s2[n] & ~q.prev[n];
        assign fall_o[n] = ~q.s2[n] &  q.prev[n];
    end
endmodule

// File: rtl/tach_trig.sv
module tach_trig
    import tach_pkg::*;
#(
    parameter int NUM_CH   = 4,
    parameter int NUM_PROF = 3,
    parameter int DIV_W    = 2,
    parameter int WIN_W    = 16,
    localparam int CH_W    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    localparam int PROF_W  = (NUM_PROF > 1) ? $clog2(NUM_PROF) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_CH-1:0]         trig_i,
    input  logic [NUM_CH-1:0]         chan_en_i,
    input  logic [2*NUM_CH-1:0]       src_lo_i,
    input  logic [NUM_CH-1:0]         src_hi_i,
    input  logic [PROF_W*NUM_PWM-1:0] port_prof_i,
    input  logic [2*NUM_PROF-1:0]     prof_mode_i,
    input  logic [DIV_W*NUM_PROF-1:0] prof_div_i,
    input  logic [WIN_W*NUM_PROF-1:0] prof_win_i,
    output logic                      start_o,
    output logic [CH_W-1:0]           ch_o,
    output logic [1:0]                mode_o,
    output logic [DIV_W-1:0]          div_o,
    output logic [WIN_W-1:0]          win_o
);
    typedef struct packed {
        logic [NUM_CH-1:0] trig;
        logic              start;
        logic [CH_W-1:0]   ch;
        logic [1:0]        mode;
        logic [DIV_W-1:0]  div;
        logic [WIN_W-1:0]  win;
    } trig_t;

    trig_t d, q;
    logic [NUM_CH-1:0] rise;
    logic [CH_W-1:0]   sel;
    logic [SRC_W-1:0]  src;
    logic [PROF_W-1:0] prof_raw;
    logic [PROF_W-1:0] prof;

    always_comb begin
        d      = q;
        d.trig = trig_i;
        rise   = trig_i & ~q.trig & chan_en_i;
        sel    = '0;
        for (int i = NUM_CH - 1; i >= 0; i--) begin
            if (rise[i]) sel = CH_W'(i);
        end
        src      = {src_hi_i[sel], src_lo_i[2*sel +: 2]};
        prof_raw = port_prof_i[PROF_W*src +: PROF_W];
        prof     = (32'(prof_raw) < NUM_PROF) ? prof_raw : '0;
        d.start  = |rise;
        if (|rise) begin
            d.ch   = sel;
            d.mode = prof_mode_i[2*prof +: 2];
            d.div  = prof_div_i[DIV_W*prof +: DIV_W];
            d.win  = prof_win_i[WIN_W*prof +: WIN_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign start_o = q.start;
    assign ch_o    = q.ch;
    assign mode_o  = q.mode;
    assign div_o   = q.div;
    assign win_o   = q.win;

    logic chk_armed_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chk_armed_q <= 1'b0;
        else        chk_armed_q <= 1'b1;
    end

    // R8: a start is only issued for a channel that was enabled
    p_start_enabled_r8: assert property (@(posedge clk) disable iff (!rst_n || !chk_armed_q)
        start_o |-> (($past(chan_en_i) & (NUM_CH'(1) << ch_o)) != '0));
endmodule

// File: rtl/tach_meas.sv
module tach_meas
    import tach_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int DIV_W  = 2,
    parameter int WIN_W  = 16,
    localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    localparam int PRE_W = 2 * (2 ** DIV_W - 1) + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [CH_W-1:0]   ch_i,
    input  logic [1:0]        mode_i,
    input  logic [DIV_W-1:0]  div_i,
    input  logic [WIN_W-1:0]  win_i,
    input  logic [NUM_CH-1:0] rise_i,
    input  logic [NUM_CH-1:0] fall_i,
    output logic [RES_W-1:0]  result_o
);
    typedef struct packed {
        meas_state_e       st;
        logic [CH_W-1:0]   ch;
        logic [1:0]        mode;
        logic [DIV_W-1:0]  div;
        logic [WIN_W-1:0]  win;
        logic [PRE_W-1:0]  pre;
        logic [CNT_W-1:0]  cnt;
        logic [WIN_W:0]    elap;
        logic              done;
        logic [CNT_W-1:0]  res;
    } meas_t;

    meas_t d, q;
    logic [PRE_W:0]   dval;
    logic [PRE_W-1:0] divmax;
    logic             tick;
    logic             hit;
    logic             timeout;
    logic [WIN_W:0]   elap_inc;
    logic [CNT_W-1:0] cnt_inc;

    always_comb begin
        d        = q;
        dval     = (PRE_W+1)'(4) << {q.div, 1'b0};
        divmax   = PRE_W'(dval - 1'b1);
        tick     = (q.pre == divmax);
        elap_inc = q.elap + 1'b1;
        timeout  = tick && (elap_inc >= {1'b0, q.win});
        cnt_inc  = (q.cnt == '1) ? q.cnt : q.cnt + CNT_W'(tick);
        case (edge_mode_e'(q.mode))
            EDGE_FALL: hit = fall_i[q.ch];
            EDGE_RISE: hit = rise_i[q.ch];
            EDGE_BOTH: hit = rise_i[q.ch] | fall_i[q.ch];
            default:   hit = 1'b0;
        endcase

        if (start_i) begin
            d.st   = M_ARM;
            d.ch   = ch_i;
            d.mode = mode_i;
            d.div  = div_i;
            d.win  = win_i;
            d.pre  = '0;
            d.cnt  = '0;
            d.elap = '0;
            d.done = 1'b0;
            d.res  = '0;
        end else begin
            case (q.st)
                M_ARM: begin
                    if (hit) begin
                        d.st  = M_RUN;
                        d.pre = '0;
                        d.cnt = '0;
                    end else begin
                        d.pre = tick ? '0 : q.pre + 1'b1;
                        if (tick) d.elap = elap_inc;
                        if (timeout) begin
                            d.st   = M_IDLE;
                            d.done = 1'b1;
                            d.res  = '1;
                        end
                    end
                end
                M_RUN: begin
                    if (hit) begin
                        d.st   = M_IDLE;
                        d.done = 1'b1;
                        d.res  = cnt_inc;
                    end else begin
                        d.pre = tick ? '0 : q.pre + 1'b1;
                        d.cnt = cnt_inc;
                        if (tick) d.elap = elap_inc;
                        if (timeout) begin
                            d.st   = M_IDLE;
                            d.done = 1'b1;
                            d.res  = '1;
                        end
                    end
                end
                default: d.st = M_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign result_o = {q.done, {(RES_W-1-CNT_W){1'b0}}, q.res};

    // R2: a start always leaves the done flag clear on the next cycle
    p_start_clears_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> !result_o[RES_W-1]);

    // R6: finishing without a start edge can only mean the saturated code
    p_timeout_code_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(q.done) && ($past(q.st) == M_ARM)) |-> (q.res == '1));

    // R3: the posted result is held while nothing is in progress
    p_idle_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((q.st == M_IDLE) && !start_i) |=> $stable(result_o));

    // R4: the prescaler never passes the selected divide
    p_pre_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        q.pre <= divmax);
endmodule

// File: rtl/tach_engine.sv
module tach_engine
    import tach_pkg::*;
#(
    parameter int NUM_CH   = 4,
    parameter int NUM_PROF = 3,
    parameter int DIV_W    = 2,
    parameter int WIN_W    = 16,
    localparam int CH_W    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    localparam int PROF_W  = (NUM_PROF > 1) ? $clog2(NUM_PROF) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_CH-1:0]         tach_i,
    input  logic [NUM_CH-1:0]         chan_en_i,
    input  logic [2*NUM_CH-1:0]       src_lo_i,
    input  logic [NUM_CH-1:0]         src_hi_i,
    input  logic [PROF_W*NUM_PWM-1:0] port_prof_i,
    input  logic [2*NUM_PROF-1:0]     prof_mode_i,
    input  logic [DIV_W*NUM_PROF-1:0] prof_div_i,
    input  logic [WIN_W*NUM_PROF-1:0] prof_win_i,
    input  logic [NUM_CH-1:0]         trig_i,
    output logic [RES_W-1:0]          result_o
);
    logic [NUM_CH-1:0] rise;
    logic [NUM_CH-1:0] fall;
    logic              start;
    logic [CH_W-1:0]   ch;
    logic [1:0]        mode;
    logic [DIV_W-1:0]  div;
    logic [WIN_W-1:0]  win;

    tach_sync #(.NUM_CH(NUM_CH)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .tach_i (tach_i),
        .rise_o (rise),
        .fall_o (fall)
    );

    tach_trig #(
        .NUM_CH   (NUM_CH),
        .NUM_PROF (NUM_PROF),
        .DIV_W    (DIV_W),
        .WIN_W    (WIN_W)
    ) u_trig (
        .clk         (clk),
        .rst_n       (rst_n),
        .trig_i      (trig_i),
        .chan_en_i   (chan_en_i),
        .src_lo_i    (src_lo_i),
        .src_hi_i    (src_hi_i),
        .port_prof_i (port_prof_i),
        .prof_mode_i (prof_mode_i),
        .prof_div_i  (prof_div_i),
        .prof_win_i  (prof_win_i),
        .start_o     (start),
        .ch_o        (ch),
        .mode_o      (mode),
        .div_o       (div),
        .win_o       (win)
    );

    tach_meas #(
        .NUM_CH (NUM_CH),
        .DIV_W  (DIV_W),
        .WIN_W  (WIN_W)
    ) u_meas (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start),
        .ch_i     (ch),
        .mode_i   (mode),
        .div_i    (div),
        .win_i    (win),
        .rise_i   (rise),
        .fall_i   (fall),
        .result_o (result_o)
    );
endmodule

// File: tb/test_tach_engine.sv
`timescale 1ns/1ps
module test_tach_engine;
    localparam int NCH = 4;
    localparam int NPF = 3;
    localparam int DW  = 2;
    localparam int WW  = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [NCH-1:0]   tach = '0;
    logic [NCH-1:0]   chan_en = '0;
    logic [2*NCH-1:0] src_lo = '0;
    logic [NCH-1:0]   src_hi = '0;
    logic [15:0]      port_prof = '0;
    logic [2*NPF-1:0] prof_mode = '0;
    logic [DW*NPF-1:0] prof_div = '0;
    logic [WW*NPF-1:0] prof_win = '0;
    logic [NCH-1:0]   trig = '0;
    logic [31:0]      result;

    int hi_len [NCH] = '{10, 10, 10, 10};
    int lo_len [NCH] = '{10, 10, 10, 10};
    bit run    [NCH] = '{0, 0, 0, 0};
    int tc     [NCH] = '{0, 0, 0, 0};

    int total = 0;
    int fails = 0;

    always #2.5 clk = ~clk;

    tach_engine i_tach_engine (
        .clk         (clk),
        .rst_n       (rst_n),
        .tach_i      (tach),
        .chan_en_i   (chan_en),
        .src_lo_i    (src_lo),
        .src_hi_i    (src_hi),
        .port_prof_i (port_prof),
        .prof_mode_i (prof_mode),
        .prof_div_i  (prof_div),
        .prof_win_i  (prof_win),
        .trig_i      (trig),
        .result_o    (result)
    );

    initial begin
        forever begin
            @(negedge clk);
            for (int i = 0; i < NCH; i++) begin
                if (run[i]) begin
                    tc[i]++;
                    if (tach[i] && tc[i] >= hi_len[i]) begin
                        tach[i] = 1'b0; tc[i] = 0;
                    end else if (!tach[i] && tc[i] >= lo_len[i]) begin
                        tach[i] = 1'b1; tc[i] = 0;
                    end
                end
            end
        end
    end

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic set_prof(input int p, input int mode, input int dv, input int win);
        prof_mode[2*p +: 2] = 2'(mode);
        prof_div[DW*p +: DW] = DW'(dv);
        prof_win[WW*p +: WW] = WW'(win);
    endtask

    task automatic route(input int ch, input int port, input int pidx);
        src_lo[2*ch +: 2] = 2'(port);
        src_hi[ch] = 1'(port >> 2);
        port_prof[2*port +: 2] = 2'(pidx);
    endtask

    task automatic fire(input logic [NCH-1:0] bits);
        @(negedge clk); trig = '0;
        @(negedge clk); trig = bits;
        repeat (3) @(negedge clk);
    endtask

    task automatic wait_done(input int cap);
        for (int k = 0; k < cap; k++) begin
            if (result[31]) break;
            @(negedge clk);
        end
    endtask

    function automatic logic [31:0] done_val(input int cnt);
        return {1'b1, 11'b0, 20'(cnt)};
    endfunction

    initial begin
        repeat (190000) @(posedge clk);
        total++; fails++;
        $display("FAIL watchdog: got hung expected finish");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        logic [31:0] held;
        int drops;
        repeat (4) @(negedge clk);
        check("R1 reset result", result, 32'h0);
        rst_n = 1'b1;
        chan_en = 4'b1111;
        for (int i = 0; i < NCH; i++) run[i] = 1'b1;

        // R4 R5 R3: sweep of divide and edge mode on channel 0 via port 0, profile 0
        route(0, 0, 0);
        for (int dv = 0; dv < 3; dv++) begin
            for (int m = 0; m < 3; m++) begin
                for (int v = 0; v < 2; v++) begin
                    int d, exp;
                    d = 4 << (2 * dv);
                    if (m < 2) begin
                        hi_len[0] = (v == 0) ? 37 : 100;
                        lo_len[0] = (v == 0) ? 53 : 60;
                        exp = (hi_len[0] + lo_len[0]) / d;
                    end else begin
                        hi_len[0] = (v == 0) ? 45 : 120;
                        lo_len[0] = hi_len[0];
                        exp = hi_len[0] / d;
                    end
                    set_prof(0, m, dv, 60000);
                    repeat (2) @(negedge clk);
                    fire(4'b0001);
                    if (dv == 0 && m == 0 && v == 0)
                        check("R2 done clear after trigger", {31'b0, result[31]}, 32'h0);
                    wait_done(3000);
                    check((m == 2) ? "R5 both edges" : "R4 R5 single edge", result, done_val(exp));
                end
            end
        end

        // R2: trigger held high starts no new reading
        drops = 0;
        for (int k = 0; k < 400; k++) begin
            @(negedge clk);
            if (!result[31]) drops++;
        end
        check("R2 held trigger no restart", 32'(drops), 32'h0);

        // R6: no tach activity, window of 10 ticks at divide 4
        run[1] = 1'b0;
        route(1, 1, 1);
        set_prof(1, 1, 0, 10);
        fire(4'b0010);
        repeat (15) @(negedge clk);
        check("R6 not done before window", {31'b0, result[31]}, 32'h0);
        wait_done(500);
        check("R6 timeout code", result, 32'h800F_FFFF);

        // R5: reserved mode lets no edge qualify
        run[1] = 1'b1; hi_len[1] = 25; lo_len[1] = 25;
        set_prof(1, 3, 0, 40);
        fire(4'b0010);
        wait_done(1000);
        check("R5 reserved mode times out", result, 32'h800F_FFFF);

        // R7: routing through high source bit and through an out-of-range profile index
        hi_len[0] = 37; lo_len[0] = 53;
        set_prof(0, 1, 0, 60000);
        set_prof(2, 1, 1, 60000);
        route(2, 5, 2);
        hi_len[2] = 80; lo_len[2] = 80;
        route(3, 6, 3);
        hi_len[3] = 30; lo_len[3] = 34;
        repeat (2) @(negedge clk);
        fire(4'b0100);
        wait_done(3000);
        check("R7 port 5 profile 2", result, done_val(160 / 16));
        fire(4'b1000);
        wait_done(3000);
        check("R7 index 3 uses profile 0", result, done_val(64 / 4));

        // R8: disabled channel trigger is ignored
        held = result;
        chan_en = 4'b1110;
        repeat (2) @(negedge clk);
        fire(4'b0001);
        repeat (300) @(negedge clk);
        check("R8 disabled trigger ignored", result, held);
        chan_en = 4'b1111;

        // R9: simultaneous triggers, lowest index wins
        set_prof(1, 1, 0, 60000);
        route(1, 1, 1);
        hi_len[1] = 25; lo_len[1] = 25;
        repeat (2) @(negedge clk);
        fire(4'b0110);
        wait_done(3000);
        check("R9 lowest index", result, done_val(50 / 4));

        // R10: retrigger abandons the running reading
        fire(4'b0100);
        repeat (20) @(negedge clk);
        fire(4'b1000);
        wait_done(3000);
        check("R10 restart on new trigger", result, done_val(64 / 4));

        // R11: settings captured at start
        set_prof(0, 1, 0, 60000);
        repeat (2) @(negedge clk);
        fire(4'b0001);
        repeat (5) @(negedge clk);
        set_prof(0, 1, 2, 60000);
        wait_done(3000);
        check("R11 captured divide", result, done_val(90 / 4));

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule